// File: doc/BRIEF.md
# Single-Channel Word DMA Controller

This block moves a run of 32-bit words between a memory port and a streaming peripheral port. Software programs three 32-bit registers: a start address, a block word (number of words per block in the low halfword, number of blocks in the high halfword) and a control word. Writing the control word with its run bit set starts the job. The same bit reads back as the busy flag. The direction bit chooses whether words flow from the peripheral into memory or from memory out to the peripheral.

Each word takes one memory request, held until it is granted, and one valid/ready handshake on the peripheral side. The address register advances by four bytes per word and always shows the next address. At the end of a job the block raises a one-cycle done pulse. In repeat mode the run bit stays set, and the word counter reloads from the block register so the next job follows at once. The address continues from where it stopped. A request for tag-chained transfers is refused: the block raises an error flag and starts nothing.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset all three registers read 0, and done, err, mem_req, pi_ready and po_valid are all low.
- R2: Writing the control register (index 2) with bit 24 = 1 and bit 10 = 0 starts a job. Bit 24 reads 1 while the job runs and reads 0 once a job in non-repeat mode has finished.
- R3: With control bit 0 = 0, words accepted on the peripheral input are written to memory. With bit 0 = 1, words read from memory are presented on the peripheral output, in address order.
- R4: The number of words in a job equals block size (bits 15:0 of register index 1) times block count (bits 31:16). A field that is zero counts as one.
- R5: The address register (index 0) increases by 4 for each completed word and reads back its current value.
- R6: done is high for exactly one cycle at the end of each job.
- R7: With control bit 9 = 1, bit 24 stays set at the end of a job and a new job of the same length starts at the following address. A control write during a job that clears bit 9 lets the current job be the last one, and bit 24 then clears.
- R8: A control write with bits 24 and 10 both set sets err, leaves bit 24 at 0 and starts no transfer. The next control write without that combination clears err.
- R9: While bit 24 is set, writes to the address and block registers are ignored. Control writes change only bit 9.
- R10: A memory request keeps its address and data stable until granted. Exactly one memory access and one peripheral handshake take place per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index: 0 address, 1 block, 2 control |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the indexed register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access accepted this cycle; read data valid |
| mem_rdata | input | 32 | Read data |
| pi_valid | input | 1 | Peripheral input word valid |
| pi_ready | output | 1 | Channel accepts a peripheral input word |
| pi_data | input | 32 | Peripheral input word |
| po_valid | output | 1 | Peripheral output word valid |
| po_ready | input | 1 | Peripheral takes the output word |
| po_data | output | 32 | Peripheral output word |
| done | output | 1 | One-cycle end-of-job pulse |
| err | output | 1 | Unsupported-mode error flag |

## Verification
Every block size from 0 to 3 is combined with every block count from 0 to 2 in both directions. This separates the zero-as-one rule from a plain product and shows whether a word is dropped or repeated at block boundaries. Grant, input-valid and output-ready each stall on their own periodic pattern, so a request that moves forward early or is counted twice shows up as wrong memory contents or a wrong final address. Separate runs write the address, block and control registers in the middle of a job, chain repeat-mode jobs and then stop them, and ask for tag mode. These runs show ignored writes, reloading and refusal at the register read-back and at the ports.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int REG_W = 32;

  localparam logic [1:0] IDX_ADDR  = 2'd0;
  localparam logic [1:0] IDX_BLOCK = 2'd1;
  localparam logic [1:0] IDX_CTRL  = 2'd2;

  // control bit positions seen by software
  localparam int CB_DIR  = 0;
  localparam int CB_REP  = 9;
  localparam int CB_TAG  = 10;
  localparam int CB_RUN  = 24;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_TAKE,   // wait for peripheral input word
    SQ_STORE,  // write word to memory
    SQ_FETCH,  // read word from memory
    SQ_GIVE    // present word to peripheral
  } seq_state_t;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              word_step,
  input  logic              job_end,
  output logic              go,
  output logic              run,
  output logic              dir,
  output logic              rep,
  output logic              err,
  output logic [REG_W-1:0]  cur_addr,
  output logic [HALF_W-1:0] blk_size,
  output logic [HALF_W-1:0] blk_cnt
);
  localparam int ADDR_INC = REG_W / 8;

  logic [REG_W-1:0] addr_q, addr_d;
  logic [REG_W-1:0] blk_q, blk_d;
  logic dir_q, dir_d, rep_q, rep_d, tag_q, tag_d;
  logic run_q, run_d, err_q, err_d, go_q, go_d;

  logic wr_addr, wr_blk, wr_ctl;
  assign wr_addr = cfg_we && (cfg_addr == IDX_ADDR);
  assign wr_blk  = cfg_we && (cfg_addr == IDX_BLOCK);
  assign wr_ctl  = cfg_we && (cfg_addr == IDX_CTRL);

  always_comb begin
    addr_d = addr_q;
    blk_d  = blk_q;
    dir_d  = dir_q;
    rep_d  = rep_q;
    tag_d  = tag_q;
    run_d  = run_q;
    err_d  = err_q;
    go_d   = 1'b0;

    if (word_step)              addr_d = addr_q + ADDR_INC;
    else if (wr_addr && !run_q) addr_d = cfg_wdata;

    if (wr_blk && !run_q) blk_d = cfg_wdata;

    if (wr_ctl) begin
      if (run_q) begin
        rep_d = cfg_wdata[CB_REP];
      end else begin
        dir_d = cfg_wdata[CB_DIR];
        rep_d = cfg_wdata[CB_REP];
        tag_d = cfg_wdata[CB_TAG];
        err_d = cfg_wdata[CB_RUN] && cfg_wdata[CB_TAG];
        if (cfg_wdata[CB_RUN] && !cfg_wdata[CB_TAG]) begin
          run_d = 1'b1;
          go_d  = 1'b1;
        end
      end
    end

    if (job_end && !rep_q) run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      blk_q  <= '0;
      dir_q  <= 1'b0;
      rep_q  <= 1'b0;
      tag_q  <= 1'b0;
      run_q  <= 1'b0;
      err_q  <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      addr_q <= addr_d;
      blk_q  <= blk_d;
      dir_q  <= dir_d;
      rep_q  <= rep_d;
      tag_q  <= tag_d;
      run_q  <= run_d;
      err_q  <= err_d;
      go_q   <= go_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      IDX_ADDR:  cfg_rdata = addr_q;
      IDX_BLOCK: cfg_rdata = blk_q;
      IDX_CTRL: begin
        cfg_rdata[CB_DIR] = dir_q;
        cfg_rdata[CB_REP] = rep_q;
        cfg_rdata[CB_TAG] = tag_q;
        cfg_rdata[CB_RUN] = run_q;
      end
      default: cfg_rdata = '0;
    endcase
  end

  assign go       = go_q;
  assign run      = run_q;
  assign dir      = dir_q;
  assign rep      = rep_q;
  assign err      = err_q;
  assign cur_addr = addr_q;
  assign blk_size = blk_q[HALF_W-1:0];
  assign blk_cnt  = blk_q[2*HALF_W-1:HALF_W];

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_step |=> addr_q == $past(addr_q) + ADDR_INC);

  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !word_step && (wr_addr || wr_blk)) |=> ($stable(addr_q) && $stable(blk_q)));

  assert_tag_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !run_q && cfg_wdata[CB_RUN] && cfg_wdata[CB_TAG]) |=> (!run_q && err_q && !go_q));

  assert_start_sets_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> run_q);
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              dir,
  input  logic              rep,
  input  logic [HALF_W-1:0] blk_size,
  input  logic [HALF_W-1:0] blk_cnt,
  output logic              word_step,
  output logic              job_end,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [REG_W-1:0]  mem_wdata,
  input  logic              mem_gnt,
  input  logic [REG_W-1:0]  mem_rdata,
  input  logic              pi_valid,
  output logic              pi_ready,
  input  logic [REG_W-1:0]  pi_data,
  output logic              po_valid,
  input  logic              po_ready,
  output logic [REG_W-1:0]  po_data
);
  localparam int LEN_W = 2 * HALF_W;

  seq_state_t st_q, st_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic [REG_W-1:0] buf_q, buf_d;
  logic done_q;

  logic [HALF_W-1:0] eff_size, eff_cnt;
  logic [LEN_W-1:0]  job_len;
  logic              last_word;
  seq_state_t        first_st;

  assign eff_size  = (blk_size == '0) ? HALF_W'(1) : blk_size;
  assign eff_cnt   = (blk_cnt  == '0) ? HALF_W'(1) : blk_cnt;
  assign job_len   = LEN_W'(eff_size) * LEN_W'(eff_cnt);
  assign last_word = (left_q == LEN_W'(1));
  assign first_st  = dir ? SQ_FETCH : SQ_TAKE;

  always_comb begin
    st_d      = st_q;
    left_d    = left_q;
    buf_d     = buf_q;
    word_step = 1'b0;
    job_end   = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    pi_ready  = 1'b0;
    po_valid  = 1'b0;

    case (st_q)
      SQ_IDLE: begin
        if (go) begin
          left_d = job_len;
          st_d   = first_st;
        end
      end
      SQ_TAKE: begin
        pi_ready = 1'b1;
        if (pi_valid) begin
          buf_d = pi_data;
          st_d  = SQ_STORE;
        end
      end
      SQ_STORE: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_gnt) word_step = 1'b1;
      end
      SQ_FETCH: begin
        mem_req = 1'b1;
        if (mem_gnt) begin
          buf_d = mem_rdata;
          st_d  = SQ_GIVE;
        end
      end
      SQ_GIVE: begin
        po_valid = 1'b1;
        if (po_ready) word_step = 1'b1;
      end
      default: st_d = SQ_IDLE;
    endcase

    if (word_step) begin
      if (last_word) begin
        job_end = 1'b1;
        if (rep) begin
          left_d = job_len;
          st_d   = first_st;
        end else begin
          st_d = SQ_IDLE;
        end
      end else begin
        left_d = left_q - LEN_W'(1);
        st_d   = first_st;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      left_q <= '0;
      buf_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
      buf_q  <= buf_d;
      done_q <= job_end;
    end
  end

  assign mem_wdata = buf_q;
  assign po_data   = buf_q;
  assign done      = done_q;

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_wdata)));

  assert_out_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (po_valid && !po_ready) |=> (po_valid && $stable(po_data)));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_IDLE) |-> (!mem_req && !pi_ready && !po_valid));

  assert_one_side_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(pi_ready && po_valid));
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic [31:0] mem_rdata,
  input  logic        pi_valid,
  output logic        pi_ready,
  input  logic [31:0] pi_data,
  output logic        po_valid,
  input  logic        po_ready,
  output logic [31:0] po_data,
  output logic        done,
  output logic        err
);
  logic go, run, dir, rep, word_step, job_end;
  logic [HALF_W-1:0] blk_size, blk_cnt;

  dma_chan_regs #(.HALF_W(HALF_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .word_step(word_step), .job_end(job_end),
    .go(go), .run(run), .dir(dir), .rep(rep), .err(err),
    .cur_addr(mem_addr), .blk_size(blk_size), .blk_cnt(blk_cnt)
  );

  dma_chan_seq #(.HALF_W(HALF_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .go(go), .dir(dir), .rep(rep), .blk_size(blk_size), .blk_cnt(blk_cnt),
    .word_step(word_step), .job_end(job_end), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .pi_valid(pi_valid), .pi_ready(pi_ready), .pi_data(pi_data),
    .po_valid(po_valid), .po_ready(po_ready), .po_data(po_data)
  );

  assert_busy_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || pi_ready || po_valid) |-> run);
endmodule

// File: tb/sim_dma_chan_ctrl.sv
`timescale 1ns/1ps
module sim_dma_chan_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic pi_valid, pi_ready, po_valid, po_ready;
  logic [31:0] pi_data, po_data;
  logic done, err;

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] mem [0:63];
  logic gnt_ok = 1'b0, in_ok = 1'b0, out_ok = 1'b0;
  int cyc = 0;
  logic [31:0] in_seed = '0;
  int in_cnt = 0, out_cnt = 0, out_bad = 0, wr_cnt = 0, done_cnt = 0, done_dbl = 0;
  int out_base = 0;
  logic done_prev = 1'b0;

  assign mem_gnt   = mem_req && gnt_ok;
  assign mem_rdata = mem[mem_addr[7:2]];
  assign pi_valid  = in_ok;
  assign pi_data   = in_seed + 32'(in_cnt);
  assign po_ready  = out_ok;

  dma_chan_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .pi_valid(pi_valid), .pi_ready(pi_ready), .pi_data(pi_data),
    .po_valid(po_valid), .po_ready(po_ready), .po_data(po_data),
    .done(done), .err(err)
  );

  function automatic logic [31:0] pat(input int j);
    return 32'h5A00_0000 + 32'(j) * 32'h0000_0101;
  endfunction

  // stall patterns, changed away from the active edge
  initial forever begin
    @(negedge clk);
    cyc++;
    gnt_ok = (cyc % 3) != 0;
    in_ok  = (cyc % 4) != 1;
    out_ok = (cyc % 5) != 2;
  end

  // bench-side memory and peripheral models
  always @(posedge clk) begin
    if (mem_req && mem_gnt && mem_we) begin
      mem[mem_addr[7:2]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (pi_valid && pi_ready) in_cnt <= in_cnt + 1;
    if (po_valid && po_ready) begin
      if (po_data !== pat(out_base + out_cnt)) out_bad <= out_bad + 1;
      out_cnt <= out_cnt + 1;
    end
    if (done) done_cnt <= done_cnt + 1;
    if (done && done_prev) done_dbl <= done_dbl + 1;
    done_prev <= done;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_done(input int target);
    int t = 0;
    while (done_cnt < target && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(done_cnt >= target, "R6 done timeout", 32'(done_cnt), 32'(target));
  endtask

  task automatic clear_counts();
    @(negedge clk);
    in_cnt = 0; out_cnt = 0; out_bad = 0; wr_cnt = 0; done_cnt = 0; done_dbl = 0;
  endtask

  task automatic run_job(input bit d, input int sz, input int ct, input int base);
    logic [31:0] v;
    int n = ((sz == 0) ? 1 : sz) * ((ct == 0) ? 1 : ct);
    for (int j = 0; j < 64; j++) mem[j] = d ? pat(j) : 32'h0;
    in_seed = 32'h1000_0000 + 32'(base * 256 + sz * 16 + ct);
    out_base = base;
    clear_counts();
    wr(2'd0, 32'(base * 4));
    wr(2'd1, {16'(ct), 16'(sz)});
    wr(2'd2, (32'h1 << 24) | 32'(d));
    wait_done(1);
    repeat (3) @(negedge clk);
    check(done_cnt == 1 && done_dbl == 0, "R6 one pulse", 32'(done_cnt), 32'd1);
    if (d) begin
      check(out_cnt == n, "R4 output word count", 32'(out_cnt), 32'(n));
      check(out_bad == 0, "R3 output data order", 32'(out_bad), 32'd0);
      check(wr_cnt == 0, "R3 no memory writes when reading", 32'(wr_cnt), 32'd0);
    end else begin
      check(in_cnt == n, "R4 input word count", 32'(in_cnt), 32'(n));
      check(wr_cnt == n, "R10 one write per word", 32'(wr_cnt), 32'(n));
      for (int i = 0; i < n; i++)
        check(mem[base + i] == in_seed + 32'(i), "R3 memory data", mem[base + i], in_seed + 32'(i));
      check(mem[base + n] == 32'h0, "R4 no extra word", mem[base + n], 32'h0);
    end
    rd(2'd0, v);
    check(v == 32'(base * 4 + 4 * n), "R5 final address", v, 32'(base * 4 + 4 * n));
    rd(2'd2, v);
    check(v[24] == 1'b0, "R2 run bit cleared", v, {7'd0, 1'b0, 24'(v)});
  endtask

  initial begin
    logic [31:0] v;
    int idle_act;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), v);
      check(v == 32'h0, "R1 register reset", v, 32'h0);
    end
    check({done, err, mem_req, pi_ready, po_valid} == 5'b0, "R1 outputs idle",
          {27'd0, done, err, mem_req, pi_ready, po_valid}, 32'h0);

    // R2 R3 R4 R5 R6 R10: sweep sizes, counts and directions
    for (int d = 0; d < 2; d++)
      for (int sz = 0; sz < 4; sz++)
        for (int ct = 0; ct < 3; ct++)
          run_job(d[0], sz, ct, 4 + sz);

    // R9: register writes during a job
    for (int j = 0; j < 64; j++) mem[j] = 32'h0;
    in_seed = 32'h2000_0000;
    clear_counts();
    wr(2'd0, 32'd32);
    wr(2'd1, 32'h0001_0004);
    wr(2'd2, 32'h0100_0000);
    wr(2'd0, 32'h0000_0100);
    wr(2'd1, 32'h0000_0005);
    wr(2'd2, 32'h0100_0001);
    wait_done(1);
    repeat (2) @(negedge clk);
    check(in_cnt == 4, "R9 block write ignored", 32'(in_cnt), 32'd4);
    rd(2'd0, v);
    check(v == 32'd48, "R9 address write ignored", v, 32'd48);
    rd(2'd1, v);
    check(v == 32'h0001_0004, "R9 block register kept", v, 32'h0001_0004);
    rd(2'd2, v);
    check(v[0] == 1'b0, "R9 direction kept", v, 32'h0);
    for (int i = 0; i < 4; i++)
      check(mem[8 + i] == in_seed + 32'(i), "R9 data at original address", mem[8 + i], in_seed + 32'(i));

    // R7: repeat mode, then stop after the current job
    for (int j = 0; j < 64; j++) mem[j] = 32'h0;
    in_seed = 32'h3000_0000;
    clear_counts();
    wr(2'd0, 32'd64);
    wr(2'd1, 32'h0001_0002);
    wr(2'd2, (32'h1 << 24) | (32'h1 << 9));
    wait_done(2);
    wr(2'd2, 32'h0100_0000);
    rd(2'd2, v);
    check(v[24] == 1'b1 && v[9] == 1'b0, "R7 run kept, repeat cleared", v, 32'h0100_0000);
    wait_done(3);
    repeat (3) @(negedge clk);
    check(done_cnt == 3, "R7 three jobs", 32'(done_cnt), 32'd3);
    check(in_cnt == 6, "R7 reloaded length", 32'(in_cnt), 32'd6);
    rd(2'd0, v);
    check(v == 32'd88, "R7 address continues", v, 32'd88);
    rd(2'd2, v);
    check(v[24] == 1'b0, "R7 run cleared after last job", v, 32'h0);
    for (int i = 0; i < 6; i++)
      check(mem[16 + i] == in_seed + 32'(i), "R7 data", mem[16 + i], in_seed + 32'(i));

    // R8: tag mode refused
    clear_counts();
    wr(2'd2, (32'h1 << 24) | (32'h1 << 10));
    idle_act = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (mem_req || pi_ready || po_valid) idle_act++;
    end
    check(idle_act == 0, "R8 no transfer", 32'(idle_act), 32'd0);
    check(err == 1'b1, "R8 err set", {31'd0, err}, 32'd1);
    rd(2'd2, v);
    check(v[24] == 1'b0 && v[10] == 1'b1, "R8 run stays 0", v, 32'h0000_0400);
    check(done_cnt == 0, "R8 no done", 32'(done_cnt), 32'd0);
    wr(2'd2, 32'h0);
    check(err == 1'b0, "R8 err cleared", {31'd0, err}, 32'd0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule